// File: doc/BRIEF.md
# Multiprocessor 9-bit UART receiver

This block receives 9-bit asynchronous frames on a shared multi-drop line where one master addresses several slaves. Each frame is a low start bit, eight payload bits least significant first, a ninth flag bit and a high stop bit. The line is synchronised, then sampled once per bit at its centre using a 16x sample-enable input supplied from outside.

A wake bit held in the control register selects address-listening mode. While it is set, only frames with the ninth bit at 1 are examined. Their payload is compared with an own-code register, and a match clears the wake bit and raises the receive interrupt. While the wake bit is clear, every well-formed frame is accepted and interrupts. Software sets the wake bit again to go back to listening.

The receive path is a four-state machine. In IDLE it waits for a falling edge on the line (IDLE->START). START checks the line at mid-bit: a high level is a glitch (START->IDLE), a low level is a valid start (START->BITS). BITS takes nine centre samples (BITS->STOP after the ninth). STOP samples the stop bit and hands over the frame (STOP->IDLE).

Top module: `mp9_uart_rx`

## Requirements
- R1: After reset, the wake bit, the frame-error flag, the received byte, the received ninth bit and the own code all read 0, and `rx_irq` is low.
- R2: With the wake bit at 0, every frame whose stop bit is 1 is accepted. Its payload is read at address 1 with the first bit received in bit 0, its ninth bit is read in bit 0 of address 2, and `rx_irq` pulses high for exactly one clock.
- R3: With the wake bit at 1, a frame whose ninth bit is 0 raises no interrupt and leaves the received byte and the ninth bit unchanged.
- R4: With the wake bit at 1, a frame whose ninth bit is 1 and whose payload equals the own code clears the wake bit and pulses `rx_irq` on the same clock edge. The payload and the ninth bit are stored.
- R5: With the wake bit at 1, a frame whose ninth bit is 1 and whose payload differs from the own code raises no interrupt, stores nothing and leaves the wake bit at 1.
- R6: A low level on the line that has returned high by the middle of the start bit produces no frame, no interrupt and no frame error, and the receiver then takes the next frame normally.
- R7: A frame whose stop bit is sampled as 0 sets the frame-error flag (bit 1 of address 0 and the `frame_err` port). It raises no interrupt, stores nothing and is not used for address matching. Writing address 0 with bit 1 set clears the flag.
- R8: A write to address 0 sets the wake bit to bit 0 of the written data. If this write lands on the same edge as a hardware clear from an address match, the written value is kept.
- R9: The own code is written and read at address 3, and it is the value compared against in R4 and R5.
- R10: After a frame error, while the line stays low, no new frame starts. Reception resumes only after the line has returned high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 3 own code |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 byte, 2 ninth bit, 3 own code |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| rx_irq | output | 1 | One-clock receive interrupt pulse |
| frame_err | output | 1 | Sticky frame-error flag |

## Verification
The hardest case to reach from the ports is a software write to the wake bit landing on the same clock edge as the hardware clear from an address match. That edge falls a few cycles after the middle of the stop bit, and it cannot be seen from outside until it has happened. The bench reaches it by holding a control write with the wake bit set across the whole matching frame. The write is then certainly present on the collision edge, and the bench checks that the interrupt still fires while the wake bit stays at 1.

// File: rtl/mp9_pkg.sv
package mp9_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_NINE = 2'd2;
    localparam logic [1:0] REG_OWN  = 2'd3;

    localparam int CTRL_WAKE_BIT = 0;
    localparam int CTRL_FERR_BIT = 1;
endpackage

// File: rtl/mp9_rx_fsm.sv
module mp9_rx_fsm
    import mp9_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd_s,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              nine,
    output logic              stop_ok
);
    localparam int NBITS = DATA_W + 1;
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(NBITS + 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);

    rx_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [NBITS-1:0] shift_q;
    logic             prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                RX_IDLE:  if (prev_q && !rxd_s) state_d = RX_START;
                RX_START: if (cnt_q == MID) state_d = rxd_s ? RX_IDLE : RX_BITS;
                RX_BITS:  if (cnt_q == LAST && idx_q == LAST_IDX) state_d = RX_STOP;
                RX_STOP:  if (cnt_q == LAST) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    // counters, shifter and frame outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            prev_q  <= 1'b0;
            done    <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev_q <= rxd_s;
                unique case (state_q)
                    RX_IDLE: begin
                        cnt_q <= '0;
                        idx_q <= '0;
                    end
                    RX_START: begin
                        cnt_q <= (cnt_q == MID) ? '0 : cnt_q + 1'b1;
                        idx_q <= '0;
                    end
                    RX_BITS: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            shift_q <= {rxd_s, shift_q[NBITS-1:1]};
                            idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            done    <= 1'b1;
                            stop_ok <= rxd_s;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign data = shift_q[DATA_W-1:0];
    assign nine = shift_q[NBITS-1];
endmodule

// File: rtl/mp9_wake_gate.sv
module mp9_wake_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              nine,
    input  logic              stop_ok,
    input  logic [DATA_W-1:0] own_code,
    input  logic              ctrl_wr,
    input  logic              wr_wake,
    input  logic              wr_ferr_clr,
    output logic              accept,
    output logic              wake,
    output logic              ferr,
    output logic              irq
);
    logic good, match, wake_clr;

    always_comb begin
        good     = done && stop_ok;
        match    = nine && (data == own_code);
        accept   = good && (!wake || match);
        wake_clr = good && wake && match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake <= 1'b0;
            ferr <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= accept;
            if (ctrl_wr)       wake <= wr_wake;
            else if (wake_clr) wake <= 1'b0;
            if (done && !stop_ok)         ferr <= 1'b1;
            else if (ctrl_wr && wr_ferr_clr) ferr <= 1'b0;
        end
    end
endmodule

// File: rtl/mp9_uart_rx.sv
module mp9_uart_rx
    import mp9_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_irq,
    output logic              frame_err
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rxd;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate
    assign rxd_s = sync_q[SYNC_STAGES-1];

    logic              fr_done, fr_nine, fr_stop_ok;
    logic [DATA_W-1:0] fr_data;

    mp9_rx_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rxd_s   (rxd_s),
        .done    (fr_done),
        .data    (fr_data),
        .nine    (fr_nine),
        .stop_ok (fr_stop_ok)
    );

    logic              ctrl_wr, own_wr, accept, wake_q;
    logic [DATA_W-1:0] data_q, own_q;
    logic              nine_q;

    assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
    assign own_wr  = wr_en && (wr_addr == REG_OWN);

    mp9_wake_gate #(.DATA_W(DATA_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (fr_done),
        .data        (fr_data),
        .nine        (fr_nine),
        .stop_ok     (fr_stop_ok),
        .own_code    (own_q),
        .ctrl_wr     (ctrl_wr),
        .wr_wake     (wr_data[CTRL_WAKE_BIT]),
        .wr_ferr_clr (wr_data[CTRL_FERR_BIT]),
        .accept      (accept),
        .wake        (wake_q),
        .ferr        (frame_err),
        .irq         (rx_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            nine_q <= 1'b0;
            own_q  <= '0;
        end else begin
            if (accept) begin
                data_q <= fr_data;
                nine_q <= fr_nine;
            end
            if (own_wr) own_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_CTRL: begin
                rd_data[CTRL_WAKE_BIT] = wake_q;
                rd_data[CTRL_FERR_BIT] = frame_err;
            end
            REG_DATA: rd_data = data_q;
            REG_NINE: rd_data[0] = nine_q;
            REG_OWN:  rd_data = own_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mp9_uart_rx_chk.sv
module mp9_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wake,
    input logic              ferr,
    input logic              rx_irq,
    input logic              fr_done,
    input logic              nine_q,
    input logic [DATA_W-1:0] data_q,
    input logic [DATA_W-1:0] own_q
);
    logic past_ok;
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    irq_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rx_irq |-> $past(fr_done));

    // R4
    wake_clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $fell(wake) && !$past(ctrl_wr) |-> rx_irq);

    // R5
    listen_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rx_irq && $past(wake) && $stable(own_q) |-> nine_q && (data_q == own_q));

    // R7
    ferr_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(ferr) |-> !rx_irq);

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(ctrl_wr) |-> wake == $past(wr_data[0]));
endmodule

bind mp9_uart_rx mp9_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wake    (wake_q),
    .ferr    (frame_err),
    .rx_irq  (rx_irq),
    .fr_done (fr_done),
    .nine_q  (nine_q),
    .data_q  (data_q),
    .own_q   (own_q)
);

// File: tb/mp9_uart_rx_bench.sv
module mp9_uart_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;
    localparam int NVEC       = 8;

    // {wake_set, own[7:0], nine, data[7:0], exp_irq, exp_wake}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 8'h5A, 1'b0, 8'hA5, 1'b1, 1'b0},
        {1'b0, 8'h5A, 1'b1, 8'h3C, 1'b1, 1'b0},
        {1'b1, 8'h5A, 1'b0, 8'h11, 1'b0, 1'b1},
        {1'b1, 8'h5A, 1'b1, 8'h22, 1'b0, 1'b1},
        {1'b1, 8'h5A, 1'b1, 8'h5A, 1'b1, 1'b0},
        {1'b0, 8'h5A, 1'b0, 8'h81, 1'b1, 1'b0},
        {1'b1, 8'h01, 1'b1, 8'h01, 1'b1, 1'b0},
        {1'b0, 8'h01, 1'b0, 8'hFF, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       rx_irq, frame_err;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    logic [7:0] exp_data = 8'h00;
    logic       exp_nine = 1'b0;

    mp9_uart_rx u_mp9_uart_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .rx_irq(rx_irq), .frame_err(frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        int tdiv;
        tdiv = 0;
        forever begin
            @(negedge clk);
            tick16 = (tdiv == TICK_DIV - 1);
            tdiv = (tdiv + 1) % TICK_DIV;
        end
    end

    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic hold_line(input logic v, input int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b8, input logic stp);
        hold_line(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold_line(d[i], BIT_CLKS);
        hold_line(b8, BIT_CLKS);
        hold_line(stp, BIT_CLKS);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_rx(input string tag);
        logic [7:0] v;
        reg_read(2'd1, v);
        check(v == exp_data, tag, v, exp_data);
        reg_read(2'd2, v);
        check(v[0] == exp_nine, tag, v[0], exp_nine);
    endtask

    initial begin
        logic [7:0] v;
        int base;
        #(CLK_PERIOD * 300000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int base;
        repeat (4) @(negedge clk);
        // R1 reset values
        check(rx_irq == 1'b0, "R1 irq", rx_irq, 0);
        check(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        reg_read(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 0);
        reg_read(2'd1, v); check(v == 8'h00, "R1 data", v, 0);
        reg_read(2'd2, v); check(v == 8'h00, "R1 nine", v, 0);
        reg_read(2'd3, v); check(v == 8'h00, "R1 own", v, 0);
        rst_n = 1'b1;
        hold_line(1'b1, BIT_CLKS);

        // table walk: R2 R3 R4 R5 R9
        for (int k = 0; k < NVEC; k++) begin
            logic [19:0] e;
            e = VEC[k];
            reg_write(2'd3, e[18:11]);
            reg_read(2'd3, v);
            check(v == e[18:11], "R9 own code readback", v, e[18:11]);
            reg_write(2'd0, {7'd0, e[19]});
            base = irq_cnt;
            send_frame(e[9:2], e[10], 1'b1);
            check((irq_cnt - base) == int'(e[1]), "R2/R3/R4/R5 irq count", irq_cnt - base, e[1]);
            reg_read(2'd0, v);
            check(v[0] == e[0], "R4/R5 wake bit", v[0], e[0]);
            if (e[1]) begin
                exp_data = e[9:2];
                exp_nine = e[10];
            end
            check_rx("R2/R3 stored frame");
        end

        // R6 short low glitch
        base = irq_cnt;
        reg_write(2'd0, 8'h00);
        hold_line(1'b0, 4 * TICK_DIV);
        hold_line(1'b1, 3 * BIT_CLKS);
        check(irq_cnt == base, "R6 glitch irq", irq_cnt - base, 0);
        check(frame_err == 1'b0, "R6 glitch ferr", frame_err, 0);
        check_rx("R6 glitch data");
        send_frame(8'h6B, 1'b0, 1'b1);
        exp_data = 8'h6B; exp_nine = 1'b0;
        check(irq_cnt == base + 1, "R6 recovery irq", irq_cnt - base, 1);
        check_rx("R6 recovery data");

        // R7 / R10 framing error on a matching select frame
        reg_write(2'd3, 8'h77);
        reg_write(2'd0, 8'h01);
        base = irq_cnt;
        hold_line(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold_line(v[0] ^ v[0] ^ ((8'h77 >> i) & 1'b1), BIT_CLKS);
        hold_line(1'b1, BIT_CLKS);
        hold_line(1'b0, BIT_CLKS);
        hold_line(1'b0, 4 * BIT_CLKS);
        check(frame_err == 1'b1, "R7 ferr set", frame_err, 1);
        check(irq_cnt == base, "R7 no irq", irq_cnt - base, 0);
        reg_read(2'd0, v);
        check(v == 8'h03, "R7 wake kept and ferr bit", v, 8'h03);
        check_rx("R7 nothing stored");
        check(irq_cnt == base, "R10 no frame while low", irq_cnt - base, 0);
        hold_line(1'b1, 2 * BIT_CLKS);
        reg_write(2'd0, 8'h03);
        check(frame_err == 1'b0, "R7 ferr cleared", frame_err, 0);
        send_frame(8'h77, 1'b1, 1'b1);
        exp_data = 8'h77; exp_nine = 1'b1;
        check(irq_cnt == base + 1, "R10 resumes after high", irq_cnt - base, 1);
        reg_read(2'd0, v);
        check(v == 8'h00, "R4 wake cleared after match", v, 0);
        check_rx("R10 stored");

        // R8 write colliding with hardware clear
        reg_write(2'd3, 8'h44);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h01;
        base = irq_cnt;
        send_frame(8'h44, 1'b1, 1'b1);
        wr_en = 1'b0;
        exp_data = 8'h44; exp_nine = 1'b1;
        check(irq_cnt == base + 1, "R8 irq on collision", irq_cnt - base, 1);
        reg_read(2'd0, v);
        check(v[0] == 1'b1, "R8 write wins", v[0], 1);
        check_rx("R8 stored");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule